// File: doc/BRIEF.md
# Serial Decoded-Bit Output with Re-Encode Error Flag

This block streams every hard-decision bit leaving a Viterbi decoder onto a serial data line, unformatted, together with a per-bit reliability flag and a framing window. The decoder delivers one decoded bit per strobe. With the same strobe it delivers the four hard-decided code bits and the puncture mask for the trellis step that is entering the decoder. An internal delay line of `DEC_LAT` strobes lines those code bits up with the decoded bit that they produced. A rate-1/4, constraint-length-7 convolutional encoder re-encodes the decoded stream. The flag rises when a re-encoded code bit disagrees with the delayed received code bit at a position that was actually transmitted.

Output uses a burst clock derived from the system clock by an eight-phase divider. A slot of eight cycles carries one bit. The clock line is high during the second half of a slot, but only when that slot holds a new bit. Data, flag and window change only at slot boundaries, so each of them is steady for four cycles on either side of the rising clock edge. The window line has two meanings, selected by a mode input. In one mode it separates fast-information data from main-service data. In the other it pulses on the first bit of a selected sub-channel.

Top module: `vit_bitout`

## Requirements
- R1: `bit_clk` is high during divider phases 4 to 7 of a slot that carries a new bit, and it is low in every other cycle. Each accepted strobe yields exactly one pulse, four cycles wide.
- R2: A strobe accepted on a clock edge is presented at the first slot boundary that follows it. A slot boundary is the edge on which the divider phase wraps from 7 to 0. The bit is then held for the whole eight-cycle slot. Bits leave in arrival order, and strobes must be at least 8 cycles apart.
- R3: With `win_mode` = 1, `bit_win` equals the fast-information tag (`dec_fic`) of the bit being presented: 1 for fast-information bits and 0 for main-service bits.
- R4: With `win_mode` = 0, `bit_win` equals the sub-channel start tag (`dec_sub_start`) of the bit being presented. It is high only for the first bit of a selected sub-channel.
- R5: The re-encoder has K = 7 and four generators (octal): code bit 0 uses 133, bit 1 uses 171, bit 2 uses 145 and bit 3 uses 133. The generator MSB taps the current decoded bit and the LSB taps the oldest one. A bit tagged `dec_frame_start` is encoded with a cleared history.
- R6: The decoded bit of strobe n is compared with the code bits and mask supplied on strobe n−`DEC_LAT`. Until `DEC_LAT` strobes have occurred after reset, the mask is taken as all zero, so the flag is 0.
- R7: `bit_err` is the OR of (re-encoded bit i XOR delayed code bit i) over every i whose delayed mask bit i is 1. Mask bit i belongs to code bit i, and a bit with mask 0 is punctured and never raises the flag.
- R8: During reset all outputs are 0 and the divider phase is 0. The first slot boundary falls on the eighth clock edge after reset release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock (divided by 8 for the bit clock) |
| rst_n | input | 1 | asynchronous active-low reset |
| win_mode | input | 1 | window meaning: 1 = information/service split, 0 = sub-channel start |
| dec_vld | input | 1 | strobe: new decoded bit and new code-bit set |
| dec_bit | input | 1 | decoded hard-decision bit |
| dec_frame_start | input | 1 | decoded bit is the first of a frame |
| dec_fic | input | 1 | decoded bit belongs to the fast information channel |
| dec_sub_start | input | 1 | decoded bit is the first of a selected sub-channel |
| cw_bits | input | 4 | hard code bits entering the decoder this strobe |
| cw_mask | input | 4 | puncture mask for cw_bits (1 = transmitted) |
| bit_clk | output | 1 | burst bit clock |
| bit_dat | output | 1 | serial decoded bit |
| bit_err | output | 1 | re-encode error flag |
| bit_win | output | 1 | framing window |

## Verification
The embedded assertions hold on every cycle for four things: the strobe-spacing rule, no pending bit is overwritten before it is presented, the data stays steady at a clock rising edge, and the pulse lasts more than one cycle. They also check that the delay line yields an all-zero mask before it has filled, that a frame start clears the encoder history, and that an all-zero mask never raises the flag. Only the bench scenarios can show the actual generator taps and the lag of `DEC_LAT` strobes. The same holds for the two window meanings and the exact slot in which each bit appears. The bench shows these by driving random and consistently encoded streams, with injected errors at punctured and unpunctured positions, and by comparing against its own model.

// File: rtl/bsout_pkg.sv
package bsout_pkg;
  localparam int CONS_LEN = 7;
  localparam int HIST_W   = CONS_LEN - 1;
  localparam int N_CODE   = 4;
  localparam int PH_W     = 3;
  // generator i sits at GEN_VEC[i*CONS_LEN +: CONS_LEN], MSB taps the current bit
  localparam logic [N_CODE*CONS_LEN-1:0] GEN_VEC =
    {7'o133, 7'o145, 7'o171, 7'o133};

  typedef struct packed {
    logic dat;
    logic err;
    logic win;
  } slot_t;
endpackage

// File: rtl/bsout_dly.sv
module bsout_dly #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0] stg [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     stg[g] <= '0;
      else if (shift) stg[g] <= src;
    end
  end

  assign dout = stg[DEPTH-1];

  // checker: count shifts since reset, saturating at DEPTH
  logic [CW-1:0] fill_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                  fill_q <= '0;
    else if (shift && (fill_q != CW'(DEPTH)))    fill_q <= fill_q + 1'b1;
  end

  // R6
  dly_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_q < CW'(DEPTH)) |-> (dout == '0));
endmodule

// File: rtl/bsout_renc.sv
module bsout_renc
  import bsout_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              restart,
  input  logic              bit_in,
  input  logic [N_CODE-1:0] code_ref,
  input  logic [N_CODE-1:0] mask,
  output logic              mis
);
  logic [HIST_W-1:0]   hist_q, hist_nxt, hist_use;
  logic [CONS_LEN-1:0] win_bits;
  logic [N_CODE-1:0]   enc;

  always_comb begin
    hist_use = restart ? '0 : hist_q;
    win_bits = {bit_in, hist_use};
    for (int i = 0; i < N_CODE; i++) begin
      enc[i] = ^(win_bits & GEN_VEC[i*CONS_LEN +: CONS_LEN]);
    end
    mis      = |((enc ^ code_ref) & mask);
    hist_nxt = step ? {bit_in, hist_use[HIST_W-1:1]} : hist_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_nxt;
  end

  // R5
  hist_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && restart) |=> (hist_q == {$past(bit_in), {(HIST_W-1){1'b0}}}));

  // R7
  punct_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !mis);
endmodule

// File: rtl/bsout_ser.sv
module bsout_ser
  import bsout_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  push,
  input  slot_t din,
  output logic  out_clk,
  output slot_t dout
);
  logic [PH_W-1:0] ph_q, ph_nxt;
  logic            pend_q, pend_nxt;
  logic            act_q, act_nxt;
  slot_t           hold_q, hold_nxt;
  slot_t           out_q, out_nxt;
  logic            bound, load;

  always_comb begin
    bound    = (ph_q == {PH_W{1'b1}});
    load     = bound && pend_q;
    ph_nxt   = ph_q + 1'b1;
    hold_nxt = push ? din : hold_q;
    pend_nxt = push ? 1'b1 : (load ? 1'b0 : pend_q);
    out_nxt  = load ? hold_q : out_q;
    act_nxt  = bound ? pend_q : act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= '0;
      pend_q <= 1'b0;
      act_q  <= 1'b0;
      hold_q <= '0;
      out_q  <= '0;
    end else begin
      ph_q   <= ph_nxt;
      pend_q <= pend_nxt;
      act_q  <= act_nxt;
      hold_q <= hold_nxt;
      out_q  <= out_nxt;
    end
  end

  assign out_clk = act_q && ph_q[PH_W-1];
  assign dout    = out_q;

  // checker: cycles since last push, saturating at 7
  logic [2:0] gap_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            gap_q <= 3'd7;
    else if (push)         gap_q <= 3'd0;
    else if (gap_q != 3'd7) gap_q <= gap_q + 1'b1;
  end

  // R2
  push_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (gap_q == 3'd7));

  // R2
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!pend_q || load));

  // R1
  steady_at_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_clk) |-> $stable(out_q));

  // R1
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_clk) |=> out_clk);
endmodule

// File: rtl/vit_bitout.sv
module vit_bitout
  import bsout_pkg::*;
#(
  parameter int DEC_LAT = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       win_mode,
  input  logic       dec_vld,
  input  logic       dec_bit,
  input  logic       dec_frame_start,
  input  logic       dec_fic,
  input  logic       dec_sub_start,
  input  logic [3:0] cw_bits,
  input  logic [3:0] cw_mask,
  output logic       bit_clk,
  output logic       bit_dat,
  output logic       bit_err,
  output logic       bit_win
);
  localparam int DW = 2 * N_CODE;

  logic [DW-1:0]     dly_out;
  logic [N_CODE-1:0] d_code, d_mask;
  logic              mis;
  slot_t             slot_in, slot_out;

  bsout_dly #(.W(DW), .DEPTH(DEC_LAT)) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .shift (dec_vld),
    .din   ({cw_mask, cw_bits}),
    .dout  (dly_out)
  );

  assign d_code = dly_out[N_CODE-1:0];
  assign d_mask = dly_out[DW-1:N_CODE];

  bsout_renc u_renc (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (dec_vld),
    .restart  (dec_frame_start),
    .bit_in   (dec_bit),
    .code_ref (d_code),
    .mask     (d_mask),
    .mis      (mis)
  );

  always_comb begin
    slot_in.dat = dec_bit;
    slot_in.err = mis;
    slot_in.win = win_mode ? dec_fic : dec_sub_start;
  end

  bsout_ser u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (dec_vld),
    .din     (slot_in),
    .out_clk (bit_clk),
    .dout    (slot_out)
  );

  assign bit_dat = slot_out.dat;
  assign bit_err = slot_out.err;
  assign bit_win = slot_out.win;
endmodule

// File: tb/vit_bitout_tb.sv
module vit_bitout_tb;
  localparam int LAT = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_mode = 1'b1;
  logic dec_vld = 1'b0, dec_bit = 1'b0, dec_frame_start = 1'b0;
  logic dec_fic = 1'b0, dec_sub_start = 1'b0;
  logic [3:0] cw_bits = '0, cw_mask = '0;
  logic bit_clk, bit_dat, bit_err, bit_win;

  always #10 clk = ~clk;

  vit_bitout #(.DEC_LAT(LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .win_mode(win_mode), .dec_vld(dec_vld),
    .dec_bit(dec_bit), .dec_frame_start(dec_frame_start), .dec_fic(dec_fic),
    .dec_sub_start(dec_sub_start), .cw_bits(cw_bits), .cw_mask(cw_mask),
    .bit_clk(bit_clk), .bit_dat(bit_dat), .bit_err(bit_err), .bit_win(bit_win)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int err_hi = 0, err_lo = 0;

  int gen [4] = '{7'o133, 7'o171, 7'o145, 7'o133};

  // reference model state
  int m_ph = 0;
  bit m_pend = 0, m_act = 0;
  bit h_dat = 0, h_err = 0, h_win = 0;
  bit o_dat = 0, o_err = 0, o_win = 0;
  bit e_clk = 0;
  bit hist_q [$];
  logic [7:0] dq [$];

  function automatic bit enc_bit(int g, bit cur, bit hist [$]);
    bit r = cur & gen[g][6];
    for (int t = 1; t < 7; t++)
      if (t <= hist.size()) r ^= hist[t-1] & gen[g][6-t];
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_pend = 0; m_act = 0;
      h_dat = 0; h_err = 0; h_win = 0;
      o_dat = 0; o_err = 0; o_win = 0; e_clk = 0;
      hist_q.delete(); dq.delete();
    end else begin
      bit ld, flag;
      logic [7:0] dl;
      flag = 0;
      if (dec_vld) begin
        // R6: code/mask pushed LAT strobes ago, zero before the line fills
        dl = 8'h00;
        if (dq.size() == LAT) dl = dq.pop_front();
        dq.push_back({cw_mask, cw_bits});
        if (dec_frame_start) hist_q.delete();   // R5
        for (int g = 0; g < 4; g++)              // R7
          if (dl[4+g] && (enc_bit(g, dec_bit, hist_q) != dl[g])) flag = 1;
        hist_q.push_front(dec_bit);
        if (hist_q.size() > 6) void'(hist_q.pop_back());
      end
      ld = (m_ph == 7) && m_pend;
      if (ld) begin
        o_dat = h_dat; o_err = h_err; o_win = h_win; m_act = 1;
      end else if (m_ph == 7) m_act = 0;
      if (dec_vld) begin
        h_dat = dec_bit; h_err = flag;
        h_win = win_mode ? dec_fic : dec_sub_start;   // R3 R4
        m_pend = 1;
      end else if (ld) m_pend = 0;
      m_ph = (m_ph + 1) % 8;
      e_clk = m_act && (m_ph >= 4);
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      chk("R1 bit_clk", bit_clk, e_clk);
      chk("R2 bit_dat", bit_dat, o_dat);
      chk("R5 R6 R7 bit_err", bit_err, o_err);
      chk("R3 R4 bit_win", bit_win, o_win);
      if (rst_n && bit_clk && o_err) err_hi++;
      if (rst_n && bit_clk && !o_err) err_lo++;
    end
  end

  task automatic send(bit b, bit fs, bit fic, bit sub, logic [3:0] c,
                      logic [3:0] m, int gap);
    @(negedge clk);
    dec_vld = 1; dec_bit = b; dec_frame_start = fs; dec_fic = fic;
    dec_sub_start = sub; cw_bits = c; cw_mask = m;
    @(negedge clk);
    dec_vld = 0; dec_frame_start = 0; dec_sub_start = 0;
    repeat (gap - 1) @(negedge clk);
  endtask

  bit strm [$];
  function automatic logic [3:0] enc_step(int idx);
    bit h [$];
    logic [3:0] r;
    int st = idx - (idx % 40);
    for (int t = idx - 1; t >= st && h.size() < 6; t--) h.push_back(strm[t]);
    for (int g = 0; g < 4; g++) r[g] = enc_bit(g, strm[idx], h);
    return r;
  endfunction

  initial begin
    // R8: outputs low while reset held
    repeat (3) @(negedge clk);
    chk("R8 reset clk", bit_clk, 1'b0);
    chk("R8 reset dat", bit_dat, 1'b0);
    chk("R8 reset err", bit_err, 1'b0);
    chk("R8 reset win", bit_win, 1'b0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // phase 1: random stream, information/service window (R3), varied gaps
    win_mode = 1;
    for (int k = 0; k < 120; k++)
      send($urandom_range(0,1), (k % 30) == 0, (k % 30) < 8, 0,
           4'($urandom), 4'($urandom), 8 + $urandom_range(0,3));
    repeat (30) @(negedge clk);   // R1: idle, clock must stay low

    // phase 2: consistent code with injected errors, sub-channel window (R4)
    win_mode = 0;
    for (int i = 0; i < 400; i++) strm.push_back($urandom_range(0,1));
    for (int k = 0; k < 300; k++) begin
      logic [3:0] c, m;
      int di = k - LAT;
      c = enc_step(k);
      m = (k % 5 == 0) ? 4'b0011 : 4'b1111;   // R7: punctured steps
      if (k % 7 == 3) c[k % 4] = ~c[k % 4];     // R7: injected error
      send(di >= 0 ? strm[di] : 1'b0, di >= 0 && (di % 40) == 0, 0,
           (k % 25) == 0, c, m, (k % 9 == 0) ? 14 : 8);
    end
    repeat (20) @(negedge clk);
    chk("R7 saw raised flag", err_hi > 0, 1'b1);
    chk("R5 saw clean bits", err_lo > 0, 1'b1);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule